// File: doc/BRIEF.md
# Power Mode and Reset Controller

This block decides when a small processor core and its peripherals receive a clock. It runs on an always-on clock and moves among five operating states: run, idle, a sleeping part of power-down with the oscillator off, a waking part of power-down with the oscillator on and the core still gated, and an emulation test state. It filters a noisy reset pin into a clean synchronous reset. It accepts single-cycle software requests for idle or power-down. It also controls the clock-gate enables for the core and the peripherals, and the oscillator enable.

Power-down ends in two phases. First, an enabled, level-sensitive external interrupt pin held low turns the oscillator back on. The core clock then returns only after a programmable settling count has run out and every armed pin is back high. Leaving power-down this way keeps all register contents, because no reset is produced. A filtered reset leaves power-down as well, and it reinitialises the core.

A test state is selected while reset is released. The address-strobe pin must be low during reset with the program-strobe pin high, and it must still be low when reset is released. In the test state the core is held, port 0 floats, the other pins get weak pull-ups, and only a filtered reset ends the state. The oscillator model and the supply detection are outside this block. The `porN` input is the supply detector's power-good result and only initialises the registers.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: `sysRst` rises only after `rstPin` has been sampled high on RST_FILT consecutive rising edges (default 24). A shorter high pulse leaves `sysRst` low.
- R2: `sysRst` falls after the first edge on which `rstPin` is sampled low. While `sysRst` is high the outputs are core, peripheral and oscillator enables at 1, with `port0Float` and `weakPull` at 0. The state after `porN` is run.
- R3: A one-cycle `idleReq` in run gives `coreClkEn`=0 with `periClkEn`=1 and `oscEn`=1 from the next edge.
- R4: In idle, `irqPending`=1 returns the block to run on the next edge.
- R5: A `pdReq` in run gives `coreClkEn`, `periClkEn` and `oscEn` all 0 from the next edge. `pdReq` takes priority over an `idleReq` in the same cycle.
- R6: In power-down, a pin `extIntPin[i]` low with `extIntEn[i]`=1 and `extIntLevel[i]`=1 (1 = level mode) sets `oscEn`=1 on the next edge, while `coreClkEn` and `periClkEn` stay 0.
- R7: The core clock returns once the settling counter has counted `stabDelay` cycles in the waking phase and no armed pin is low. With the pin low for one cycle only, `coreClkEn` is 1 on the `stabDelay`+2nd edge after the pin fell. While an armed pin stays low the core stays gated.
- R8: In power-down, a low pin whose `extIntLevel` bit is 0 (edge mode) or whose `extIntEn` bit is 0, and `irqPending` too, leave `oscEn` at 0.
- R9: Leaving power-down through an interrupt never raises `sysRst`. A filtered reset during power-down raises `sysRst` and restores all three enables.
- R10: The test state is entered at reset release only when, on the last reset cycle, `addrStrobe`=0 and `progStrobe`=1, and `addrStrobe`=0 on the release edge. In every other case the block resumes run.
- R11: In the test state `port0Float`=1, `weakPull`=1, `oscEn`=1 and the core and peripheral enables are 0. Requests and reset pulses shorter than RST_FILT do not end the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| porN | input | 1 | Power-good, active low asynchronous initialisation |
| rstPin | input | 1 | Raw reset pin, active high |
| addrStrobe | input | 1 | Address-strobe pin level, sampled for test entry |
| progStrobe | input | 1 | Program-strobe pin level, sampled for test entry |
| idleReq | input | 1 | Software request to enter idle |
| pdReq | input | 1 | Software request to enter power-down |
| irqPending | input | 1 | Any enabled interrupt pending |
| extIntPin | input | NUM_EXT | External interrupt pin levels, active low |
| extIntEn | input | NUM_EXT | Per-pin interrupt enable |
| extIntLevel | input | NUM_EXT | Per-pin mode, 1 = level-sensitive |
| stabDelay | input | STAB_W | Oscillator settling count |
| sysRst | output | 1 | Filtered synchronous reset |
| coreClkEn | output | 1 | Core clock gate enable |
| periClkEn | output | 1 | Peripheral clock gate enable |
| oscEn | output | 1 | Oscillator enable |
| port0Float | output | 1 | Port 0 float request |
| weakPull | output | 1 | Weak pull-up request for other pins |

## Verification
The hardest case to reach from the ports is the waking phase of power-down: the interrupt pin's return to high can come before or after the settling count runs out, and the settling value can change while the count is running. Directed steps cover a long low level and a one-cycle low pulse. A random phase then enters power-down many times, toggles pin levels, masks and modes, and sometimes changes `stabDelay`. A behavioural model checks every output on every clock. Test-state entry requires a chosen strobe pattern across the release edge, so it is applied directly and also produced by random strobe levels during long random reset pulses.

// File: rtl/pmu_pkg.sv
package pmu_pkg;

  typedef enum logic [2:0] {
    PM_RUN   = 3'd0,
    PM_IDLE  = 3'd1,
    PM_SLEEP = 3'd2,
    PM_WAKE  = 3'd3,
    PM_TEST  = 3'd4
  } pmState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic stabClr;
    logic stabStep;
  } pmStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic rstActive;
    logic rstRelease;
    logic testArmed;
    logic stabDone;
    logic wakeLow;
  } pmStatus_t;

endpackage

// File: rtl/pmu_datapath.sv
module pmu_datapath
  import pmu_pkg::*;
#(
  parameter int RST_FILT = 24,
  parameter int NUM_EXT  = 2,
  parameter int STAB_W   = 8
) (
  input  logic               clk,
  input  logic               porN,
  input  logic               rstPin,
  input  logic               addrStrobe,
  input  logic               progStrobe,
  input  logic [NUM_EXT-1:0] extIntPin,
  input  logic [NUM_EXT-1:0] extIntEn,
  input  logic [NUM_EXT-1:0] extIntLevel,
  input  logic [STAB_W-1:0]  stabDelay,
  input  pmStrobe_t          strobe,
  output pmStatus_t          status
);

  localparam int RCW = $clog2(RST_FILT + 1);
  localparam logic [RCW-1:0] FILT_MAX = RCW'(RST_FILT);

  logic [RCW-1:0]    rstCnt;
  logic              rstActive;
  logic              armReg;
  logic [STAB_W-1:0] stabCnt;
  logic              stabDone;
  logic [NUM_EXT-1:0] armedLow;

  // reset pin filter: consecutive-high counter, saturating
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      rstCnt <= '0;
    end else if (!rstPin) begin
      rstCnt <= '0;
    end else if (rstCnt != FILT_MAX) begin
      rstCnt <= rstCnt + 1'b1;
    end
  end

  assign rstActive = (rstCnt == FILT_MAX);

  // test-entry sample taken on every reset cycle, last one wins
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      armReg <= 1'b0;
    end else if (rstActive) begin
      armReg <= ~addrStrobe & progStrobe;
    end
  end

  // oscillator settling counter
  assign stabDone = (stabCnt >= stabDelay);

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      stabCnt <= '0;
    end else if (strobe.stabClr) begin
      stabCnt <= '0;
    end else if (strobe.stabStep && !stabDone) begin
      stabCnt <= stabCnt + 1'b1;
    end
  end

  // per-pin wake qualification
  for (genvar i = 0; i < NUM_EXT; i++) begin : g_wake
    assign armedLow[i] = extIntEn[i] & extIntLevel[i] & ~extIntPin[i];
  end

  assign status.rstActive  = rstActive;
  assign status.rstRelease = rstActive & ~rstPin;
  assign status.testArmed  = armReg & ~addrStrobe;
  assign status.stabDone   = stabDone;
  assign status.wakeLow    = |armedLow;

endmodule

// File: rtl/pmu_control.sv
module pmu_control
  import pmu_pkg::*;
(
  input  logic      clk,
  input  logic      porN,
  input  logic      idleReq,
  input  logic      pdReq,
  input  logic      irqPending,
  input  pmStatus_t status,
  output pmStrobe_t strobe,
  output logic      coreClkEn,
  output logic      periClkEn,
  output logic      oscEn,
  output logic      port0Float,
  output logic      weakPull
);

  pmState_t state;
  pmState_t stateNext;

  always_comb begin
    stateNext       = state;
    strobe.stabClr  = 1'b0;
    strobe.stabStep = 1'b0;
    unique case (state)
      PM_RUN: begin
        if (pdReq)        stateNext = PM_SLEEP;
        else if (idleReq) stateNext = PM_IDLE;
      end
      PM_IDLE: begin
        if (irqPending) stateNext = PM_RUN;
      end
      PM_SLEEP: begin
        strobe.stabClr = 1'b1;
        if (status.wakeLow) stateNext = PM_WAKE;
      end
      PM_WAKE: begin
        strobe.stabStep = 1'b1;
        if (status.stabDone && !status.wakeLow) stateNext = PM_RUN;
      end
      PM_TEST: stateNext = PM_TEST;
      default: stateNext = PM_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      state <= PM_RUN;
    end else if (status.rstRelease) begin
      state <= status.testArmed ? PM_TEST : PM_RUN;
    end else if (status.rstActive) begin
      state <= PM_RUN;
    end else begin
      state <= stateNext;
    end
  end

  always_comb begin
    {coreClkEn, periClkEn, oscEn, port0Float, weakPull} = 5'b00000;
    if (status.rstActive) begin
      {coreClkEn, periClkEn, oscEn, port0Float, weakPull} = 5'b11100;
    end else begin
      unique case (state)
        PM_RUN:   {coreClkEn, periClkEn, oscEn, port0Float, weakPull} = 5'b11100;
        PM_IDLE:  {coreClkEn, periClkEn, oscEn, port0Float, weakPull} = 5'b01100;
        PM_SLEEP: {coreClkEn, periClkEn, oscEn, port0Float, weakPull} = 5'b00000;
        PM_WAKE:  {coreClkEn, periClkEn, oscEn, port0Float, weakPull} = 5'b00100;
        PM_TEST:  {coreClkEn, periClkEn, oscEn, port0Float, weakPull} = 5'b00111;
        default:  {coreClkEn, periClkEn, oscEn, port0Float, weakPull} = 5'b11100;
      endcase
    end
  end

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmu_pkg::*;
#(
  parameter int RST_FILT = 24,
  parameter int NUM_EXT  = 2,
  parameter int STAB_W   = 8
) (
  input  logic               clk,
  input  logic               porN,
  input  logic               rstPin,
  input  logic               addrStrobe,
  input  logic               progStrobe,
  input  logic               idleReq,
  input  logic               pdReq,
  input  logic               irqPending,
  input  logic [NUM_EXT-1:0] extIntPin,
  input  logic [NUM_EXT-1:0] extIntEn,
  input  logic [NUM_EXT-1:0] extIntLevel,
  input  logic [STAB_W-1:0]  stabDelay,
  output logic               sysRst,
  output logic               coreClkEn,
  output logic               periClkEn,
  output logic               oscEn,
  output logic               port0Float,
  output logic               weakPull
);

  pmStrobe_t strobe;
  pmStatus_t status;

  pmu_datapath #(
    .RST_FILT(RST_FILT),
    .NUM_EXT (NUM_EXT),
    .STAB_W  (STAB_W)
  ) u_dp (
    .clk        (clk),
    .porN       (porN),
    .rstPin     (rstPin),
    .addrStrobe (addrStrobe),
    .progStrobe (progStrobe),
    .extIntPin  (extIntPin),
    .extIntEn   (extIntEn),
    .extIntLevel(extIntLevel),
    .stabDelay  (stabDelay),
    .strobe     (strobe),
    .status     (status)
  );

  pmu_control u_ctl (
    .clk       (clk),
    .porN      (porN),
    .idleReq   (idleReq),
    .pdReq     (pdReq),
    .irqPending(irqPending),
    .status    (status),
    .strobe    (strobe),
    .coreClkEn (coreClkEn),
    .periClkEn (periClkEn),
    .oscEn     (oscEn),
    .port0Float(port0Float),
    .weakPull  (weakPull)
  );

  assign sysRst = status.rstActive;

endmodule

// File: rtl/pmu_checker.sv
module pmu_checker #(
  parameter int RST_FILT = 24,
  parameter int NUM_EXT  = 2
) (
  input logic               clk,
  input logic               porN,
  input logic               rstPin,
  input logic [NUM_EXT-1:0] extIntPin,
  input logic [NUM_EXT-1:0] extIntEn,
  input logic [NUM_EXT-1:0] extIntLevel,
  input logic               sysRst,
  input logic               coreClkEn,
  input logic               periClkEn,
  input logic               oscEn,
  input logic               port0Float,
  input logic               weakPull
);

  logic [15:0] hiCnt;
  logic        anyArmedLow;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN)                hiCnt <= '0;
    else if (!rstPin)         hiCnt <= '0;
    else if (hiCnt != 16'hFFFF) hiCnt <= hiCnt + 16'd1;
  end

  assign anyArmedLow = |(extIntEn & extIntLevel & ~extIntPin);

  // R1: reset only after a long enough high run on the pin
  assert_filter_R1: assert property (@(posedge clk) disable iff (!porN)
    sysRst |-> (hiCnt >= 16'(RST_FILT)));

  // R3: idle keeps the oscillator running
  assert_idle_osc_R3: assert property (@(posedge clk) disable iff (!porN || sysRst)
    (!coreClkEn && periClkEn) |-> oscEn);

  // R5: oscillator off means every clock gated
  assert_pd_gated_R5: assert property (@(posedge clk) disable iff (!porN || sysRst)
    !oscEn |-> (!coreClkEn && !periClkEn));

  // R8: sleep holds while no armed pin is low
  assert_pd_hold_R8: assert property (@(posedge clk) disable iff (!porN || sysRst)
    (!oscEn && !anyArmedLow) |=> !oscEn);

  // R7: core returns from waking phase only with armed pins high
  assert_wake_exit_R7: assert property (@(posedge clk) disable iff (!porN || sysRst)
    ($rose(coreClkEn) && !$past(sysRst) && $past(oscEn) && !$past(periClkEn)
      && !$past(port0Float)) |-> $past(!anyArmedLow));

  // R11: test state outputs
  assert_test_out_R11: assert property (@(posedge clk) disable iff (!porN || sysRst)
    port0Float |-> (weakPull && oscEn && !coreClkEn && !periClkEn));

  // R11: test state left only through filtered reset
  assert_test_sticky_R11: assert property (@(posedge clk) disable iff (!porN || sysRst)
    port0Float |=> port0Float);

endmodule

bind pwr_mode_ctrl pmu_checker #(
  .RST_FILT(RST_FILT),
  .NUM_EXT (NUM_EXT)
) u_chk (
  .clk        (clk),
  .porN       (porN),
  .rstPin     (rstPin),
  .extIntPin  (extIntPin),
  .extIntEn   (extIntEn),
  .extIntLevel(extIntLevel),
  .sysRst     (sysRst),
  .coreClkEn  (coreClkEn),
  .periClkEn  (periClkEn),
  .oscEn      (oscEn),
  .port0Float (port0Float),
  .weakPull   (weakPull)
);

// File: tb/tb_pwr_mode_ctrl.sv
`timescale 1ns/1ps
module tb_pwr_mode_ctrl;

  localparam int FILT = 24;
  localparam int NEXT = 2;
  localparam int SW   = 8;

  logic clk = 1'b0;
  logic porN = 1'b0;
  logic rstPin = 1'b0;
  logic addrStrobe = 1'b1;
  logic progStrobe = 1'b1;
  logic idleReq = 1'b0;
  logic pdReq = 1'b0;
  logic irqPending = 1'b0;
  logic [NEXT-1:0] extIntPin = '1;
  logic [NEXT-1:0] extIntEn = '0;
  logic [NEXT-1:0] extIntLevel = '0;
  logic [SW-1:0] stabDelay = 8'd5;
  logic sysRst, coreClkEn, periClkEn, oscEn, port0Float, weakPull;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pwr_mode_ctrl #(.RST_FILT(FILT), .NUM_EXT(NEXT), .STAB_W(SW)) dut (
    .clk(clk), .porN(porN), .rstPin(rstPin), .addrStrobe(addrStrobe),
    .progStrobe(progStrobe), .idleReq(idleReq), .pdReq(pdReq),
    .irqPending(irqPending), .extIntPin(extIntPin), .extIntEn(extIntEn),
    .extIntLevel(extIntLevel), .stabDelay(stabDelay), .sysRst(sysRst),
    .coreClkEn(coreClkEn), .periClkEn(periClkEn), .oscEn(oscEn),
    .port0Float(port0Float), .weakPull(weakPull)
  );

  // reference model: 0 run, 1 idle, 2 sleep, 3 wake, 4 test
  int mMode = 0;
  int mRc = 0;
  int mSc = 0;
  bit mArm = 0;

  always @(posedge clk or negedge porN) begin
    if (!porN) begin
      mMode = 0; mRc = 0; mSc = 0; mArm = 0;
    end else begin
      bit act, low;
      int nm, nsc;
      act = (mRc == FILT);
      low = |(extIntEn & extIntLevel & ~extIntPin);
      nm = mMode; nsc = mSc;
      case (mMode)
        0: if (pdReq) nm = 2; else if (idleReq) nm = 1;
        1: if (irqPending) nm = 0;
        2: begin nsc = 0; if (low) nm = 3; end
        3: begin
             if (mSc >= int'(stabDelay)) begin
               if (!low) nm = 0;
             end else nsc = mSc + 1;
           end
        default: nm = mMode;
      endcase
      if (act && !rstPin) nm = (mArm && !addrStrobe) ? 4 : 0;
      else if (act) nm = 0;
      if (act) mArm = !addrStrobe && progStrobe;
      mRc = rstPin ? ((mRc < FILT) ? mRc + 1 : mRc) : 0;
      mMode = nm; mSc = nsc;
    end
  end

  function automatic logic [5:0] expOut();
    if (mRc == FILT) return 6'b111100;
    case (mMode)
      0: return 6'b011100;
      1: return 6'b001100;
      2: return 6'b000000;
      3: return 6'b000100;
      default: return 6'b000111;
    endcase
  endfunction

  function automatic string tagOf(int m);
    case (m)
      0: return "R2/R4";
      1: return "R3";
      2: return "R8";
      3: return "R7";
      default: return "R11";
    endcase
  endfunction

  wire [5:0] dutOut = {sysRst, coreClkEn, periClkEn, oscEn, port0Float, weakPull};

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (porN && !done) begin
      total++;
      if (dutOut !== expOut()) begin
        bad++;
        $display("FAIL %s model compare: actual=%b expected=%b t=%0t",
                 (mRc == FILT) ? "R1" : tagOf(mMode), dutOut, expOut(), $time);
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired: actual=hung expected=finished");
    finishRun();
  end

  task automatic doReset(input bit a, input bit p);
    addrStrobe = a; progStrobe = p; rstPin = 1;
    cyc(FILT + 4);
    rstPin = 0;
    cyc(1);
  endtask

  task automatic enterPd();
    pdReq = 1; cyc(1); pdReq = 0;
  endtask

  initial begin
    int n;
    cyc(3);
    porN = 1;
    cyc(1);
    // R2: state after power-good is run
    chk("R2 run after porN", {sysRst, coreClkEn, periClkEn, oscEn}, 4'b0111);

    // R1: short pulse ignored
    rstPin = 1; cyc(10); rstPin = 0; cyc(2);
    chk("R1 short pulse", sysRst, 0);
    // R1: exact filter length
    rstPin = 1; cyc(FILT - 1);
    chk("R1 one short", sysRst, 0);
    cyc(1);
    chk("R1 asserted", sysRst, 1);
    chk("R2 clocks in reset", {coreClkEn, periClkEn, oscEn, port0Float}, 4'b1110);
    cyc(3);
    rstPin = 0; cyc(1);
    chk("R2 release", sysRst, 0);

    // R3 / R4 idle
    idleReq = 1; cyc(1); idleReq = 0;
    chk("R3 idle gates core", {coreClkEn, periClkEn, oscEn}, 3'b011);
    cyc(4);
    chk("R3 idle holds", coreClkEn, 0);
    irqPending = 1; cyc(1); irqPending = 0;
    chk("R4 idle exit", coreClkEn, 1);

    // R5 power-down with simultaneous idle request
    idleReq = 1; pdReq = 1; cyc(1); idleReq = 0; pdReq = 0;
    chk("R5 pd priority", {coreClkEn, periClkEn, oscEn}, 3'b000);

    // R8 ignored wake sources
    extIntEn = 2'b11; extIntLevel = 2'b01;
    extIntPin = 2'b01; irqPending = 1; cyc(5);
    chk("R8 edge-mode pin and irq ignored", oscEn, 0);
    extIntPin = 2'b11; irqPending = 0; extIntEn = 2'b10; extIntPin = 2'b10; cyc(3);
    chk("R8 masked pin ignored", oscEn, 0);
    extIntPin = 2'b11; extIntEn = 2'b11; cyc(1);

    // R6 / R7 long low level
    stabDelay = 8'd5;
    extIntPin = 2'b10; cyc(1);
    chk("R6 osc on", {coreClkEn, periClkEn, oscEn}, 3'b001);
    cyc(20);
    chk("R7 held while pin low", coreClkEn, 0);
    extIntPin = 2'b11; cyc(1);
    chk("R7 exit on high", coreClkEn, 1);
    chk("R9 no reset on irq exit", sysRst, 0);

    // R7 one-cycle low pulse timing
    enterPd();
    stabDelay = 8'd8;
    extIntPin = 2'b10; cyc(1); extIntPin = 2'b11;
    n = 1;
    while (!coreClkEn && n < 40) begin cyc(1); n++; end
    chk("R7 settle count", n, 8 + 2);

    // R9 reset exit from power-down
    enterPd();
    rstPin = 1; cyc(FILT - 1);
    chk("R9 still asleep", oscEn, 0);
    cyc(1);
    chk("R9 reset wakes", {sysRst, coreClkEn, periClkEn, oscEn}, 4'b1111);
    rstPin = 0; cyc(1);

    // R10 / R11 test entry
    doReset(0, 1);
    chk("R10 test entered", {port0Float, weakPull}, 2'b11);
    chk("R11 test clocks", {coreClkEn, periClkEn, oscEn}, 3'b001);
    addrStrobe = 1;
    idleReq = 1; pdReq = 1; cyc(1); idleReq = 0; pdReq = 0; cyc(1);
    chk("R11 requests ignored", port0Float, 1);
    rstPin = 1; cyc(6); rstPin = 0; cyc(2);
    chk("R11 short reset ignored", port0Float, 1);
    doReset(1, 1);
    chk("R11 reset leaves test", {port0Float, coreClkEn}, 2'b01);

    // R10 negative cases
    doReset(0, 0);
    chk("R10 prog strobe low", port0Float, 0);
    addrStrobe = 0; progStrobe = 1; rstPin = 1; cyc(FILT + 2);
    addrStrobe = 1; rstPin = 0; cyc(1);
    chk("R10 strobe high at release", port0Float, 0);

    // random phase, checked against the model every cycle
    for (int i = 0; i < 6000; i++) begin
      idleReq    = ($urandom % 8) == 0;
      pdReq      = ($urandom % 12) == 0;
      irqPending = ($urandom % 10) == 0;
      if (($urandom % 6) == 0) extIntPin[$urandom % NEXT] ^= 1'b1;
      if (($urandom % 40) == 0) extIntEn = NEXT'($urandom);
      if (($urandom % 40) == 0) extIntLevel = NEXT'($urandom);
      if (($urandom % 50) == 0) stabDelay = SW'($urandom % 12);
      addrStrobe = ($urandom % 3) != 0 ? addrStrobe : ~addrStrobe;
      progStrobe = ($urandom % 4) != 0;
      if (($urandom % 300) == 0) rstPin = 1;
      else if (rstPin && ($urandom % 28) == 0) rstPin = 0;
      cyc(1);
    end
    rstPin = 0;
    cyc(2);
    finishRun();
  end

endmodule